// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive buffer entries held in system memory. Four 16-bit pointers describe the table: a start, an end, a read position and a write position. Each table entry is four consecutive words. When the block is told to take a new buffer, it reads the entry at the read position through a memory read port. It then exposes the buffer address and the remaining word count to the receive path, and steps the read position forward. The step wraps back to the start pointer when it lands exactly on the end pointer.

Three things launch a fetch: a command bit written by the host, the host acknowledging the exhausted status bit, and a low-space indication from the receive path. When the step leaves the read position equal to the write position, the last buffer the host supplied has been taken, and an exhausted status bit is raised. If low space is signalled while the two positions are already equal, no fetch is made. Instead a stall flag is set, which tells the receive path to stop. The next completed fetch clears it.

Memory requests and responses use valid/ready handshakes. A request holds its address stable until it is accepted, and only one request is outstanding at a time. Responses are taken only while the block asserts response-ready. The host side is a plain register port: writes are synchronous and reads are combinational.

Top module: `rx_ring_reader`

## Requirements
- R1: After reset, all pointers, the buffer registers, the status register, the stall flag and the interrupt read as zero, and no memory request is pending.
- R2: Writes to the start (address 5), end (6), read (7) and write (8) pointers clear the low two bits when wide mode (address 1, bit 0) is set, and clear bit 0 otherwise.
- R3: A fetch reads four words at {upper (address 4), read pointer + k*step}, with k = 0..3 and step 2 in narrow mode or 4 in wide mode. Words 0..3 appear as buffer address low/high and word count low/high at addresses 9..12.
- R4: On completion the read pointer advances by 8 bytes in narrow mode or 16 bytes in wide mode. If the result equals the end pointer exactly, the read pointer is loaded with the start pointer instead.
- R5: If the read pointer equals the write pointer after the advance, status bit 5 (status address 2) is set.
- R6: Writing a 1 to status bit 5 while it is set clears it and launches a fetch. Writing a 1 while it is clear launches nothing and leaves the pointers unchanged.
- R7: Writing 1 to bit 8 of the command register (address 0) launches a fetch. That bit reads 1 while a fetch is pending or running, and reads 0 once it is done.
- R8: A one-cycle pulse on low_space_i launches a fetch when the read and write pointers differ. When they are equal, it instead sets the stall flag (stall_o, and flags address 13 bit 0) and makes no fetch.
- R9: Every completed fetch clears the stall flag.
- R10: irq_o is the OR of the status bits ANDed with the mask register (address 3), and it follows a status change one cycle later.
- R11: A memory request holds valid and address until accepted. At most one request is outstanding, and a fetch issues exactly four requests.
- R12: A launch that arrives during a running fetch is held and served after that fetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| low_space_i | input | 1 | Receive path reports its current buffer nearly full |
| stall_o | output | 1 | No resource left; reception must stop |
| irq_o | output | 1 | Masked status interrupt |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block accepts read data |
| mem_rsp_data | input | 16 | Read data word |

## Verification
The bench builds the block with its default 16-bit pointers and four-word entries, so a ring of one to four entries fits in a few hundred cycles. For both narrow and wide step sizes, it sweeps every ring length from one to four entries against every write-pointer position. It runs one more fetch than the ring holds, so every wrap and every exhausted condition is reached. The memory model throttles request acceptance and returns data derived arithmetically from the address, so each captured word and each advanced pointer is checked against a value the bench computes on its own.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int REG_W       = 16;
  localparam int ENTRY_WORDS = 4;
  localparam int HA_W        = 4;
  localparam int EXH_BIT     = 5;
  localparam int FETCH_BIT   = 8;

  localparam logic [HA_W-1:0] RA_CMD   = 4'd0;
  localparam logic [HA_W-1:0] RA_MODE  = 4'd1;
  localparam logic [HA_W-1:0] RA_STAT  = 4'd2;
  localparam logic [HA_W-1:0] RA_MASK  = 4'd3;
  localparam logic [HA_W-1:0] RA_UPPER = 4'd4;
  localparam logic [HA_W-1:0] RA_START = 4'd5;
  localparam logic [HA_W-1:0] RA_END   = 4'd6;
  localparam logic [HA_W-1:0] RA_RDP   = 4'd7;
  localparam logic [HA_W-1:0] RA_WRP   = 4'd8;
  localparam logic [HA_W-1:0] RA_BUF0  = 4'd9;
  localparam logic [HA_W-1:0] RA_BUF1  = 4'd10;
  localparam logic [HA_W-1:0] RA_CNT0  = 4'd11;
  localparam logic [HA_W-1:0] RA_CNT1  = 4'd12;
  localparam logic [HA_W-1:0] RA_FLAGS = 4'd13;

  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_ISSUE  = 2'd1,
    FS_WAIT   = 2'd2,
    FS_COMMIT = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/rx_ring_step.sv
module rx_ring_step
  import rx_ring_pkg::*;
#(
  parameter int PW    = REG_W,
  parameter int WORDS = ENTRY_WORDS
) (
  input  logic [PW-1:0] rd_i,
  input  logic [PW-1:0] start_i,
  input  logic [PW-1:0] end_i,
  input  logic [PW-1:0] wr_i,
  input  logic          wide_i,
  output logic [PW-1:0] next_o,
  output logic          meets_wr_o
);
  localparam logic [PW-1:0] STRIDE_N = PW'(WORDS * 2);
  localparam logic [PW-1:0] STRIDE_W = PW'(WORDS * 4);

  logic [PW-1:0] raw;

  always_comb begin
    raw        = rd_i + (wide_i ? STRIDE_W : STRIDE_N);
    next_o     = (raw == end_i) ? start_i : raw;
    meets_wr_o = (next_o == wr_i);
  end
endmodule

// File: rtl/rx_ring_fetch.sv
module rx_ring_fetch
  import rx_ring_pkg::*;
#(
  parameter  int PW    = REG_W,
  parameter  int WORDS = ENTRY_WORDS,
  localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int AW    = 2 * PW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      launch_i,
  input  logic                      wide_i,
  input  logic [PW-1:0]             base_i,
  input  logic [PW-1:0]             upper_i,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [AW-1:0]             mem_req_addr,
  input  logic                      mem_rsp_valid,
  output logic                      mem_rsp_ready,
  input  logic [PW-1:0]             mem_rsp_data,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [WORDS-1:0][PW-1:0]  words_o
);
  fetch_state_e  state_q;
  logic [IW-1:0] idx_q;
  logic [PW-1:0] base_q;
  logic [PW-1:0] upper_q;
  logic          wide_q;
  logic [PW-1:0] offset;
  logic          last_word;
  logic          rsp_take;
  logic [PW-1:0] words_q [WORDS];

  always_comb begin
    offset        = PW'(idx_q) << (wide_q ? 2 : 1);
    last_word     = (idx_q == IW'(WORDS - 1));
    mem_req_valid = (state_q == FS_ISSUE);
    mem_rsp_ready = (state_q == FS_WAIT);
    mem_req_addr  = {upper_q, base_q + offset};
    rsp_take      = mem_rsp_ready && mem_rsp_valid;
    busy_o        = (state_q != FS_IDLE);
    done_o        = (state_q == FS_COMMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      upper_q <= '0;
      wide_q  <= 1'b0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (launch_i) begin
          state_q <= FS_ISSUE;
          idx_q   <= '0;
          base_q  <= base_i;
          upper_q <= upper_i;
          wide_q  <= wide_i;
        end
        FS_ISSUE: if (mem_req_ready) state_q <= FS_WAIT;
        FS_WAIT: if (mem_rsp_valid) begin
          if (last_word) begin
            state_q <= FS_COMMIT;
          end else begin
            state_q <= FS_ISSUE;
            idx_q   <= idx_q + 1'b1;
          end
        end
        FS_COMMIT: state_q <= FS_IDLE;
        default:   state_q <= FS_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               words_q[g] <= '0;
      else if (rsp_take && idx_q == IW'(g))     words_q[g] <= mem_rsp_data;
    end
    assign words_o[g] = words_q[g];
  end
endmodule

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int PW    = REG_W,
  parameter int WORDS = ENTRY_WORDS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr_en,
  input  logic [HA_W-1:0]          host_addr,
  input  logic [PW-1:0]            host_wdata,
  output logic [PW-1:0]            host_rdata,
  input  logic                     low_space_i,
  input  logic                     busy_i,
  input  logic                     done_i,
  input  logic [PW-1:0]            next_rd_i,
  input  logic                     meets_wr_i,
  input  logic [WORDS-1:0][PW-1:0] words_i,
  output logic                     launch_o,
  output logic                     wide_o,
  output logic [PW-1:0]            upper_o,
  output logic [PW-1:0]            start_o,
  output logic [PW-1:0]            end_o,
  output logic [PW-1:0]            rd_o,
  output logic [PW-1:0]            wr_o,
  output logic [PW-1:0]            stat_o,
  output logic [PW-1:0]            mask_o,
  output logic                     stall_o
);
  logic          wide_q;
  logic          exh_q;
  logic          stall_q;
  logic          pend_q;
  logic [PW-1:0] mask_q, upper_q, start_q, end_q, rd_q, wr_q;
  logic [PW-1:0] aligned;
  logic          wr_cmd, wr_stat, cmd_kick, ack_kick, low_kick, low_block;
  logic          trigger;

  always_comb begin
    aligned   = wide_q ? {host_wdata[PW-1:2], 2'b00} : {host_wdata[PW-1:1], 1'b0};
    wr_cmd    = host_wr_en && host_addr == RA_CMD;
    wr_stat   = host_wr_en && host_addr == RA_STAT;
    cmd_kick  = wr_cmd && host_wdata[FETCH_BIT];
    ack_kick  = wr_stat && host_wdata[EXH_BIT] && exh_q;
    low_kick  = low_space_i && (rd_q != wr_q);
    low_block = low_space_i && (rd_q == wr_q);
    trigger   = cmd_kick || ack_kick || low_kick;
    launch_o  = !busy_i && (pend_q || trigger);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q  <= 1'b0;
      mask_q  <= '0;
      upper_q <= '0;
      start_q <= '0;
      end_q   <= '0;
      wr_q    <= '0;
    end else if (host_wr_en) begin
      unique case (host_addr)
        RA_MODE:  wide_q  <= host_wdata[0];
        RA_MASK:  mask_q  <= host_wdata;
        RA_UPPER: upper_q <= host_wdata;
        RA_START: start_q <= aligned;
        RA_END:   end_q   <= aligned;
        RA_WRP:   wr_q    <= aligned;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      exh_q   <= 1'b0;
      stall_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (host_wr_en && host_addr == RA_RDP) rd_q <= aligned;
      if (wr_stat && host_wdata[EXH_BIT])    exh_q <= 1'b0;
      if (done_i) begin
        rd_q    <= next_rd_i;
        stall_q <= 1'b0;
        if (meets_wr_i) exh_q <= 1'b1;
      end
      if (low_block) stall_q <= 1'b1;
      pend_q <= launch_o ? 1'b0 : (pend_q || trigger);
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      RA_CMD:   host_rdata[FETCH_BIT] = busy_i || pend_q;
      RA_MODE:  host_rdata[0]         = wide_q;
      RA_STAT:  host_rdata[EXH_BIT]   = exh_q;
      RA_MASK:  host_rdata = mask_q;
      RA_UPPER: host_rdata = upper_q;
      RA_START: host_rdata = start_q;
      RA_END:   host_rdata = end_q;
      RA_RDP:   host_rdata = rd_q;
      RA_WRP:   host_rdata = wr_q;
      RA_BUF0:  host_rdata = words_i[0];
      RA_BUF1:  host_rdata = words_i[1];
      RA_CNT0:  host_rdata = words_i[2];
      RA_CNT1:  host_rdata = words_i[3];
      RA_FLAGS: host_rdata[0] = stall_q;
      default:  host_rdata = '0;
    endcase
  end

  always_comb begin
    stat_o          = '0;
    stat_o[EXH_BIT] = exh_q;
  end

  assign wide_o  = wide_q;
  assign upper_o = upper_q;
  assign start_o = start_q;
  assign end_o   = end_q;
  assign rd_o    = rd_q;
  assign wr_o    = wr_q;
  assign mask_o  = mask_q;
  assign stall_o = stall_q;
endmodule

// File: rtl/rx_ring_reader.sv
module rx_ring_reader
  import rx_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_en,
  input  logic [HA_W-1:0]  host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             low_space_i,
  output logic             stall_o,
  output logic             irq_o,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [2*REG_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [REG_W-1:0] mem_rsp_data
);
  localparam int PW = REG_W;

  logic                           launch, wide, busy, fetch_done, meets_wr;
  logic [PW-1:0]                  upper, ring_start, ring_end, rd_ptr, wr_ptr, next_rd;
  logic [PW-1:0]                  stat_q, mask_q;
  logic [ENTRY_WORDS-1:0][PW-1:0] words;
  logic                           irq_q;

  rx_ring_regs #(.PW(PW), .WORDS(ENTRY_WORDS)) u_regs (
    .clk, .rst_n, .host_wr_en, .host_addr, .host_wdata, .host_rdata,
    .low_space_i,
    .busy_i(busy), .done_i(fetch_done), .next_rd_i(next_rd), .meets_wr_i(meets_wr),
    .words_i(words), .launch_o(launch), .wide_o(wide), .upper_o(upper),
    .start_o(ring_start), .end_o(ring_end), .rd_o(rd_ptr), .wr_o(wr_ptr),
    .stat_o(stat_q), .mask_o(mask_q), .stall_o(stall_o)
  );

  rx_ring_step #(.PW(PW), .WORDS(ENTRY_WORDS)) u_step (
    .rd_i(rd_ptr), .start_i(ring_start), .end_i(ring_end), .wr_i(wr_ptr),
    .wide_i(wide), .next_o(next_rd), .meets_wr_o(meets_wr)
  );

  rx_ring_fetch #(.PW(PW), .WORDS(ENTRY_WORDS)) u_fetch (
    .clk, .rst_n, .launch_i(launch), .wide_i(wide), .base_i(rd_ptr), .upper_i(upper),
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .busy_o(busy), .done_o(fetch_done), .words_o(words)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_q & mask_q);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/rx_ring_reader_chk.sv
module rx_ring_reader_chk
  import rx_ring_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [2*REG_W-1:0] mem_req_addr,
  input logic               mem_rsp_ready,
  input logic               irq_o,
  input logic [REG_W-1:0]   stat_q,
  input logic [REG_W-1:0]   mask_q,
  input logic               low_space_i,
  input logic               stall_o,
  input logic               fetch_done
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, mem_rsp_ready})); // R11
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[EXH_BIT] && mask_q[EXH_BIT]) |=> irq_o); // R10
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & mask_q)) |=> !irq_o); // R10
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> $past(low_space_i)); // R8
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done && !low_space_i |=> !stall_o); // R9
endmodule

bind rx_ring_reader rx_ring_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_ready(mem_rsp_ready), .irq_o(irq_o),
  .stat_q(stat_q), .mask_q(mask_q), .low_space_i(low_space_i), .stall_o(stall_o),
  .fetch_done(fetch_done)
);

// File: tb/tb_rx_ring_reader.sv
`timescale 1ns/1ps
module tb_rx_ring_reader;
  localparam logic [3:0] A_CMD = 0, A_MODE = 1, A_STAT = 2, A_MASK = 3, A_UPPER = 4,
                         A_START = 5, A_END = 6, A_RDP = 7, A_WRP = 8, A_BUF0 = 9,
                         A_FLAGS = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        low_space_i = 1'b0;
  logic        stall_o, irq_o;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_req_addr;
  logic [15:0] mem_rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  int hs_cnt = 0;
  int cyc = 0;
  logic        pend_m = 1'b0;
  logic [31:0] paddr_m = '0;

  always #4 clk = ~clk;

  rx_ring_reader dut (.*);

  function automatic logic [15:0] mem_fn(logic [31:0] a);
    return a[15:0] ^ {a[7:0], a[15:8]} ^ a[31:16] ^ 16'hC3A5;
  endfunction

  assign mem_req_ready = (cyc % 3) != 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      pend_m <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        pend_m  <= 1'b1;
        paddr_m <= mem_req_addr;
        hs_cnt  <= hs_cnt + 1;
      end
      if (pend_m && !mem_rsp_valid) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_fn(paddr_m);
        pend_m        <= 1'b0;
      end else if (mem_rsp_valid && mem_rsp_ready) begin
        mem_rsp_valid <= 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    host_wr_en = 1'b0; host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(A_CMD, v);
      if (!v[8]) break;
      @(negedge clk);
    end
  endtask

  task automatic check_entry(input string req, input logic [15:0] up, input logic [15:0] rp,
                             input logic wide);
    logic [15:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(4'(A_BUF0 + k), v);
      check(req, {16'h0, v}, {16'h0, mem_fn({up, rp + 16'(k * (wide ? 4 : 2))})});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v, stride, s0, e0, w0, rexp, nx, up;
    logic        exh;
    int          h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_RDP, v);   check("R1 rd ptr", v, 0);
    rd(A_STAT, v);  check("R1 status", v, 0);
    rd(A_FLAGS, v); check("R1 flags", v, 0);
    rd(A_CMD, v);   check("R1 cmd", v, 0);
    rd(A_BUF0, v);  check("R1 buffer", v, 0);
    check("R1 irq/stall/req", {irq_o, stall_o, mem_req_valid}, 0);

    // R2 pointer alignment in both modes
    wr(A_MODE, 1);
    wr(A_START, 16'h1237); rd(A_START, v); check("R2 wide start", v, 16'h1234);
    wr(A_WRP, 16'h00FF);   rd(A_WRP, v);   check("R2 wide wr", v, 16'h00FC);
    wr(A_MODE, 0);
    wr(A_END, 16'h1237);   rd(A_END, v);   check("R2 narrow end", v, 16'h1236);
    wr(A_RDP, 16'h0003);   rd(A_RDP, v);   check("R2 narrow rd", v, 16'h0002);

    // R3 R4 R5 R6 R7 R10 ring sweep
    for (int wide = 0; wide < 2; wide++) begin
      for (int ne = 1; ne <= 4; ne++) begin
        for (int wp = 0; wp < ne; wp++) begin
          stride = wide ? 16'd16 : 16'd8;
          up = 16'h0040 + 16'(ne * 2 + wide);
          s0 = 16'h0200 + 16'(wp * 32);
          e0 = s0 + 16'(ne) * stride;
          w0 = s0 + 16'(wp) * stride;
          wr(A_MODE, 16'(wide));
          wr(A_MASK, wide ? 16'h0020 : 16'h0000);
          wr(A_UPPER, up); wr(A_START, s0); wr(A_END, e0); wr(A_WRP, w0); wr(A_RDP, s0);
          rd(A_STAT, v);
          if (v[5]) wr(A_STAT, 16'h0020);
          wait_idle();
          rd(A_RDP, v); rexp = v;
          rd(A_STAT, v); exh = v[5];
          for (int f = 0; f <= ne; f++) begin
            h0 = hs_cnt;
            if (exh) wr(A_STAT, 16'h0020);   // R6 acknowledge launches the fetch
            else     wr(A_CMD, 16'h0100);    // R7 command launches the fetch
            wait_idle();
            check_entry("R3 entry words", up, rexp, wide[0]);
            check("R11 four requests", hs_cnt - h0, 4);
            nx = rexp + stride;
            if (nx == e0) nx = s0;
            rexp = nx;
            exh = (nx == w0);
            rd(A_RDP, v);  check("R4 advance/wrap", v, rexp);
            rd(A_STAT, v); check("R5 exhausted", v[5], exh);
            rd(A_CMD, v);  check("R7 cmd clear", v[8], 0);
            @(negedge clk);
            check("R10 irq", irq_o, exh & wide[0]);
          end
        end
      end
    end

    // R6 ack while clear: no fetch; R10 irq drops one cycle after clear
    wr(A_MODE, 0); wr(A_MASK, 16'h0020);
    wr(A_START, 16'h0100); wr(A_END, 16'h0120); wr(A_WRP, 16'h0108); wr(A_RDP, 16'h0100);
    wr(A_CMD, 16'h0100); wait_idle();
    rd(A_STAT, v); check("R5 exhausted set", v[5], 1);
    @(negedge clk);
    check("R10 irq high", irq_o, 1);
    wr(A_RDP, 16'h0110);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = A_STAT; host_wdata = 16'h0020;
    @(negedge clk);
    host_wr_en = 1'b0;
    check("R10 irq one cycle late", irq_o, 1);
    @(negedge clk);
    check("R10 irq dropped", irq_o, 0);
    wait_idle();
    rd(A_RDP, v); check("R6 ack fetch", v, 16'h0118);
    h0 = hs_cnt;
    wr(A_STAT, 16'h0020);
    rd(A_CMD, v); check("R6 no launch when clear", v[8], 0);
    repeat (20) @(negedge clk);
    rd(A_RDP, v); check("R6 rd unchanged", v, 16'h0118);
    check("R6 no requests", hs_cnt - h0, 0);

    // R8 low space with pointers different, then equal; R9 clear
    wr(A_WRP, 16'h0100);
    @(negedge clk); low_space_i = 1'b1; @(negedge clk); low_space_i = 1'b0;
    wait_idle();
    rd(A_RDP, v); check("R8 low space fetch", v, 16'h0100);
    check("R8 no stall", stall_o, 0);
    h0 = hs_cnt;
    @(negedge clk); low_space_i = 1'b1; @(negedge clk); low_space_i = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 stall set", stall_o, 1);
    rd(A_FLAGS, v); check("R8 stall flag reg", v[0], 1);
    rd(A_RDP, v); check("R8 no fetch", v, 16'h0100);
    check("R8 no requests", hs_cnt - h0, 0);
    wr(A_CMD, 16'h0100); wait_idle();
    check("R9 stall cleared", stall_o, 0);

    // R12 launch during running fetch is kept
    wr(A_WRP, 16'h0000); wr(A_RDP, 16'h0100);
    h0 = hs_cnt;
    wr(A_CMD, 16'h0100);
    wr(A_CMD, 16'h0100);
    wait_idle();
    rd(A_RDP, v); check("R12 two fetches", v, 16'h0110);
    check("R12 eight requests", hs_cnt - h0, 8);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule